// File: doc/BRIEF.md
# Two-Stage Interrupt Pending Controller

This block gathers up to 32 interrupt request lines into a source-pending register, qualifies them with a mask register, and moves a single winning request into an interrupt-pending register that drives one interrupt line toward the processor. Both pending registers are cleared by writing ones. A handler clears its bit in the source-pending register first, then in the interrupt-pending register. Only after both writes is the request fully acknowledged. For a level-style acknowledge, software masks the source first and then performs the two clears.

Several request bits are parents for groups of sub-requests. A small group of external pins shares one parent bit, and a larger group of external pins shares another. Each serial port contributes three sub-requests that are OR-ed onto its own parent bit.

A separate wake-mask register chooses which raw requests may wake the system while a sleep input is high. Only the four lowest-numbered request lines and the real-time-clock line can be enabled for wake. A simple word-addressed register bus reads and writes all four registers.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the source-pending and interrupt-pending registers read 0, the mask and wake-mask registers read all ones, `irq_o` is low and `wake_o` is low.
- R2: A request that is high in a cycle sets its source-pending bit at the next rising edge. A request held high keeps re-setting the bit, and in the same cycle setting wins over a write-one clear.
- R3: Writing the source-pending register (address 0) clears every bit written as 1 and leaves bits written as 0 unchanged.
- R4: The mask register (address 1) is read/write. A bit at 1 blocks that source from the interrupt-pending stage, and a bit at 0 lets it through.
- R5: While the interrupt-pending register is zero, it loads at the next edge the lowest-numbered bit that is pending and unmasked, as a one-hot value. It never holds more than one set bit.
- R6: Once the interrupt-pending register (address 2) is non-zero, it holds its value until a write to it has a 1 in the set position, which clears it. A write of 0, or a write while it is empty, changes nothing.
- R7: `irq_o` is high exactly when the interrupt-pending register is non-zero.
- R8: Bit 4 is the OR of the four low-group external pins and bit 5 is the OR of the sixteen high-group external pins. Bits 20, 21 and 22 are the ORs of the three sub-requests of serial ports 0, 1 and 2. These parent values are OR-ed with the direct request on the same bit.
- R9: Bits 0 to 3 and bit 30 of the wake-mask register (address 3) take written values. All other bits ignore writes and always read 1.
- R10: `wake_o` is high exactly when `sleep_i` is high and some effective request bit is high whose wake-mask bit is 0.
- R11: `bus_rdata_o` returns, in the same cycle, the register selected by `bus_addr_i`: 0 for source-pending, 1 for mask, 2 for interrupt-pending and 3 for wake-mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Direct request lines |
| ext_lo_i | input | 4 | Low external pin group, aggregated onto bit 4 |
| ext_hi_i | input | 16 | High external pin group, aggregated onto bit 5 |
| uart_sub_i | input | 9 | Three sub-requests per serial port, port u at bits 3u..3u+2 |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request to the processor |
| sleep_i | input | 1 | System is asleep |
| wake_o | output | 1 | Wake request |

## Verification
A request becomes visible in source-pending one rising edge after it is driven. It reaches interrupt-pending and `irq_o` on the following edge, provided that stage is empty and the bit is unmasked. Register writes take effect at the edge that ends the write cycle, while read data and `wake_o` follow their inputs within the same cycle. The bench drives every input just after a falling edge and samples all outputs one time unit later, before the next rising edge. At each rising edge it advances its own register model from the inputs it drove, so each comparison lines up with the cycle in which the result is due.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int SUBS_PER_UART = 3;

    typedef enum logic [1:0] {
        REG_SRC_PEND  = 2'd0,
        REG_MASK      = 2'd1,
        REG_INT_PEND  = 2'd2,
        REG_WAKE_MASK = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int LO_W      = 4,
    parameter int HI_W      = 16,
    parameter int NUM_UART  = 3,
    parameter int LO_PARENT = 4,
    parameter int HI_PARENT = 5,
    parameter int UART_BASE = 20
) (
    input  logic [NUM_SRC-1:0]                src_i,
    input  logic [LO_W-1:0]                   lo_i,
    input  logic [HI_W-1:0]                   hi_i,
    input  logic [NUM_UART*SUBS_PER_UART-1:0] uart_i,
    output logic [NUM_SRC-1:0]                eff_o
);
    logic [NUM_UART-1:0] uart_any;

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        assign uart_any[u] = |uart_i[u*SUBS_PER_UART +: SUBS_PER_UART];
    end

    always_comb begin
        eff_o = src_i;
        eff_o[LO_PARENT] = src_i[LO_PARENT] | (|lo_i);
        eff_o[HI_PARENT] = src_i[HI_PARENT] | (|hi_i);
        for (int u = 0; u < NUM_UART; u++) begin
            eff_o[UART_BASE+u] = src_i[UART_BASE+u] | uart_any[u];
        end
    end
endmodule

// File: rtl/irq_pend_pick.sv
module irq_pend_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] grant_o
);
    // isolate the lowest set bit
    assign grant_o = req_i & (~req_i + W'(1));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int LO_W       = 4,
    parameter int HI_W       = 16,
    parameter int NUM_UART   = 3,
    parameter int LO_PARENT  = 4,
    parameter int HI_PARENT  = 5,
    parameter int UART_BASE  = 20,
    parameter int RTC_BIT    = 30,
    parameter int WAKE_LOW_N = 4
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_SRC-1:0]                  src_i,
    input  logic [LO_W-1:0]                     ext_lo_i,
    input  logic [HI_W-1:0]                     ext_hi_i,
    input  logic [NUM_UART*SUBS_PER_UART-1:0]   uart_sub_i,
    input  logic                                bus_we_i,
    input  logic [1:0]                          bus_addr_i,
    input  logic [NUM_SRC-1:0]                  bus_wdata_i,
    output logic [NUM_SRC-1:0]                  bus_rdata_o,
    output logic                                irq_o,
    input  logic                                sleep_i,
    output logic                                wake_o
);
    localparam logic [NUM_SRC-1:0] ONE        = NUM_SRC'(1);
    localparam logic [NUM_SRC-1:0] WAKE_ALLOW = ((ONE << WAKE_LOW_N) - ONE) | (ONE << RTC_BIT);

    typedef struct packed {
        logic [NUM_SRC-1:0] srcpnd;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] intpnd;
        logic [NUM_SRC-1:0] wkmsk;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] eff_src;
    logic [NUM_SRC-1:0] grant;
    logic               wr_src, wr_mask, wr_int, wr_wake;

    irq_pend_merge #(
        .NUM_SRC  (NUM_SRC),
        .LO_W     (LO_W),
        .HI_W     (HI_W),
        .NUM_UART (NUM_UART),
        .LO_PARENT(LO_PARENT),
        .HI_PARENT(HI_PARENT),
        .UART_BASE(UART_BASE)
    ) u_merge (
        .src_i (src_i),
        .lo_i  (ext_lo_i),
        .hi_i  (ext_hi_i),
        .uart_i(uart_sub_i),
        .eff_o (eff_src)
    );

    irq_pend_pick #(.W(NUM_SRC)) u_pick (
        .req_i  (st_q.srcpnd & ~st_q.mask),
        .grant_o(grant)
    );

    assign wr_src  = bus_we_i && (bus_addr_i == REG_SRC_PEND);
    assign wr_mask = bus_we_i && (bus_addr_i == REG_MASK);
    assign wr_int  = bus_we_i && (bus_addr_i == REG_INT_PEND);
    assign wr_wake = bus_we_i && (bus_addr_i == REG_WAKE_MASK);

    always_comb begin
        st_d = st_q;
        // new requests win over a same-cycle clear
        st_d.srcpnd = (st_q.srcpnd & ~(wr_src ? bus_wdata_i : '0)) | eff_src;
        if (wr_mask) begin
            st_d.mask = bus_wdata_i;
        end
        if (st_q.intpnd != '0) begin
            st_d.intpnd = st_q.intpnd & ~(wr_int ? bus_wdata_i : '0);
        end else begin
            st_d.intpnd = grant;
        end
        if (wr_wake) begin
            st_d.wkmsk = bus_wdata_i | ~WAKE_ALLOW;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.srcpnd <= '0;
            st_q.mask   <= '1;
            st_q.intpnd <= '0;
            st_q.wkmsk  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr_i))
            REG_SRC_PEND:  bus_rdata_o = st_q.srcpnd;
            REG_MASK:      bus_rdata_o = st_q.mask;
            REG_INT_PEND:  bus_rdata_o = st_q.intpnd;
            REG_WAKE_MASK: bus_rdata_o = st_q.wkmsk;
            default:       bus_rdata_o = '0;
        endcase
    end

    assign irq_o  = |st_q.intpnd;
    assign wake_o = sleep_i && |(eff_src & ~st_q.wkmsk & WAKE_ALLOW);
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
    parameter int NUM_SRC = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] eff_src,
    input logic [NUM_SRC-1:0] srcpnd_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] intpnd_q,
    input logic               irq_o,
    input logic               sleep_i,
    input logic               wake_o,
    input logic               bus_we_i,
    input logic [1:0]         bus_addr_i,
    input logic [NUM_SRC-1:0] bus_wdata_i
);
    AST_INTPND_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(intpnd_q)); // R5

    AST_SRC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((srcpnd_q & $past(eff_src)) == $past(eff_src))); // R2

    AST_LOAD_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((intpnd_q == '0) && ((srcpnd_q & ~mask_q) != '0)) |=> irq_o); // R7

    AST_INTPND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((intpnd_q != '0) && !(bus_we_i && bus_addr_i == 2'd2)) |=> $stable(intpnd_q)); // R6

    AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == 2'd1) |=> (mask_q == $past(bus_wdata_i))); // R4

    AST_NO_WAKE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_i |-> !wake_o); // R10
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eff_src    (eff_src),
    .srcpnd_q   (st_q.srcpnd),
    .mask_q     (st_q.mask),
    .intpnd_q   (st_q.intpnd),
    .irq_o      (irq_o),
    .sleep_i    (sleep_i),
    .wake_o     (wake_o),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ALLOW = 32'h4000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [3:0]  lo = '0;
    logic [15:0] hi = '0;
    logic [8:0]  uart = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        sleep = 1'b0;
    logic        wake;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_src, m_mask, m_int, m_wk;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl u_irq_pend_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ext_lo_i(lo), .ext_hi_i(hi),
        .uart_sub_i(uart), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .sleep_i(sleep), .wake_o(wake)
    );

    // R8: parent aggregation computed from the requirement
    function automatic logic [31:0] eff_of(logic [31:0] s, logic [3:0] l, logic [15:0] h, logic [8:0] u);
        logic [31:0] e = s;
        e[4]  = e[4]  | (|l);
        e[5]  = e[5]  | (|h);
        e[20] = e[20] | (|u[2:0]);
        e[21] = e[21] | (|u[5:3]);
        e[22] = e[22] | (|u[8:6]);
        return e;
    endfunction

    function automatic logic [31:0] lowest(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'd1 << i;
        return '0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [31:0] e = eff_of(src, lo, hi, uart);
        logic [31:0] r;
        case (addr)
            2'd0: r = m_src;
            2'd1: r = m_mask;
            2'd2: r = m_int;
            default: r = m_wk;
        endcase
        chk(rdata === r, "R11 read data", rdata, r);
        chk(irq === (m_int != 0), "R7 irq", {31'd0, irq}, {31'd0, m_int != 0});
        chk(wake === (sleep && |(e & ~m_wk & ALLOW)), "R10 wake", {31'd0, wake},
            {31'd0, sleep && |(e & ~m_wk & ALLOW)});
    endtask

    task automatic model_step();
        logic [31:0] e = eff_of(src, lo, hi, uart);
        logic [31:0] ns, nm, ni, nw;
        ns = (m_src & ~((we && addr == 2'd0) ? wdata : 32'd0)) | e;   // R2 R3
        nm = (we && addr == 2'd1) ? wdata : m_mask;                    // R4
        if (m_int != 0) ni = m_int & ~((we && addr == 2'd2) ? wdata : 32'd0); // R6
        else            ni = lowest(m_src & ~m_mask);                  // R5
        nw = (we && addr == 2'd3) ? (wdata | ~ALLOW) : m_wk;           // R9
        m_src = ns; m_mask = nm; m_int = ni; m_wk = nw;
    endtask

    task automatic cyc(input logic [31:0] s, input logic [3:0] l, input logic [15:0] h,
                       input logic [8:0] u, input logic w, input logic [1:0] a,
                       input logic [31:0] d, input logic slp);
        @(negedge clk);
        src = s; lo = l; hi = h; uart = u; we = w; addr = a; wdata = d; sleep = slp;
        #1;
        check_all();
        @(posedge clk);
        model_step();
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        src = '0; lo = '0; hi = '0; uart = '0; we = 1'b0; addr = a; wdata = '0; sleep = 1'b0;
        #1;
        chk(rdata === exp, tag, rdata, exp);
        check_all();
        @(posedge clk);
        model_step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        m_src = '0; m_mask = '1; m_int = '0; m_wk = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, read before any post-reset edge acts
        addr = 2'd0; #1; chk(rdata === 32'd0, "R1 srcpnd reset", rdata, 32'd0);
        addr = 2'd1; #1; chk(rdata === 32'hFFFF_FFFF, "R1 mask reset", rdata, 32'hFFFF_FFFF);
        addr = 2'd2; #1; chk(rdata === 32'd0, "R1 intpnd reset", rdata, 32'd0);
        addr = 2'd3; #1; chk(rdata === 32'hFFFF_FFFF, "R1 wake mask reset", rdata, 32'hFFFF_FFFF);
        chk(irq === 1'b0 && wake === 1'b0, "R1 outputs reset", {30'd0, irq, wake}, 32'd0);

        // R4 R5: unmask 3 and 7, pulse both, lowest wins
        cyc('0, '0, '0, '0, 1'b1, 2'd1, ~32'h88, 1'b0);
        cyc(32'h88, '0, '0, '0, 1'b0, 2'd0, '0, 1'b0);
        rd(2'd0, 32'h88, "R2 both sources captured");
        rd(2'd2, 32'h08, "R5 lowest unmasked loaded");
        // R3 R6: full acknowledge of bit 3, then bit 7 follows
        cyc('0, '0, '0, '0, 1'b1, 2'd0, 32'h08, 1'b0);
        cyc('0, '0, '0, '0, 1'b1, 2'd2, 32'h00, 1'b0);
        rd(2'd2, 32'h08, "R6 zero write leaves intpnd");
        cyc('0, '0, '0, '0, 1'b1, 2'd2, 32'h08, 1'b0);
        rd(2'd0, 32'h80, "R3 only written bit cleared");
        rd(2'd2, 32'h80, "R6 next source after clear");
        // R2: held source survives a clear
        cyc(32'h2, '0, '0, '0, 1'b1, 2'd0, 32'h2, 1'b0);
        rd(2'd0, 32'h82, "R2 held source re-sets");
        // R4: masked source never reaches intpnd
        cyc('0, '0, '0, '0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
        cyc('0, '0, '0, '0, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        cyc(32'h100, '0, '0, '0, 1'b0, 2'd0, '0, 1'b0);
        rd(2'd2, 32'h0, "R4 masked source blocked");
        // R8: parent bits
        cyc('0, '0, '0, '0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
        cyc('0, 4'h8, 16'h0400, 9'b010_000_000, 1'b0, 2'd0, '0, 1'b0);
        rd(2'd0, 32'h0040_0030, "R8 parent aggregation");
        // R9: only allowed wake bits are writable
        cyc('0, '0, '0, '0, 1'b1, 2'd3, 32'h0, 1'b0);
        rd(2'd3, ~ALLOW, "R9 wake mask write filter");
        // R10: wake from allowed and not from others
        cyc(32'h4000_0000, '0, '0, '0, 1'b0, 2'd3, '0, 1'b1);
        chk(wake === 1'b1, "R10 rtc wakes", {31'd0, wake}, 32'd1);
        cyc(32'h0000_0400, '0, '0, '0, 1'b0, 2'd3, '0, 1'b1);
        chk(wake === 1'b0, "R10 other source no wake", {31'd0, wake}, 32'd0);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] s = $urandom & $urandom & $urandom & $urandom;
            logic        w = ($urandom % 3) == 0;
            logic [1:0]  a = 2'($urandom);
            logic [31:0] d = $urandom;
            if (w && a == 2'd1) d = d & $urandom;
            cyc(s, 4'(($urandom % 8 == 0) ? $urandom : 0), 16'(($urandom % 8 == 0) ? $urandom : 0),
                9'(($urandom % 8 == 0) ? $urandom : 0), w, a, d, 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule